// File: doc/BRIEF.md
# Two-Page LCD Command Decoder and Configuration Registers

This block sits between a byte-wide serial receiver and the rest of a small graphic LCD controller. Each received byte comes with a strobe and a command/data flag. Data bytes are passed on as single-cycle RAM write requests. Command bytes are decoded against one of two instruction pages, basic or extended. A page bit, itself written by a command that both pages accept, selects the page in use.

Decoding starts from the position of the most significant set bit of the byte, which gives the instruction class. The remaining bits are then checked against the layout of that class. Decoded fields go into configuration registers: power-down, vertical addressing, page select, display mode, temperature coefficient, bias code and operating-voltage code. Column and bank address loads leave the block as one-cycle pulses with the field value attached. The address counter that receives them is outside this block.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs hold these values: pwr_down=1, addr_vert=0, ext_page=0, disp_mode=00, temp_coef=00, bias_code=000, vop_code=0, x_value=0, y_value=0, and no pulse output is high. Strobes that arrive during reset have no effect.
- R2: A byte with byte_valid=1 and byte_is_data=1 raises wr_req for exactly the next cycle, with wr_data equal to the byte. The byte leaves every configuration register unchanged, whatever its bit pattern.
- R3: On either page, command 0b00100PVH (bit7 down to bit0) sets pwr_down=P, addr_vert=V and ext_page=H in the cycle after the strobe. A byte whose leading one is bit 5 but whose bit 4 or bit 3 is set has no effect.
- R4: On the basic page, command 0b00001D0E sets disp_mode={D,E}, with D in bit 1. The meanings are: 00 blank, 10 normal, 01 all pixels on, 11 inverse.
- R5: On the basic page:
  - 0b01000yyy gives y_load=1 for one cycle with y_value=yyy.
  - 0b1xxxxxxx gives x_load=1 for one cycle with x_value=xxxxxxx.
- R6: On the extended page:
  - 0b000001TT sets temp_coef=TT.
  - 0b00010BBB sets bias_code=BBB.
  - 0b1vvvvvvv sets vop_code=vvvvvvv.
- R7: A pattern that is valid on only one page has no effect on the other page. On the extended page, 0b1xxxxxxx raises no x_load and 0b01000yyy raises no y_load.
- R8: Command 0x00, and every command byte matching none of the layouts in R3 to R6 for the current page, changes no register and raises no pulse. Examples are a display-control byte with bit 1 set, a bias byte with bit 3 set, and 0x01.
- R9: pump_off is 1 exactly when vop_code is zero.
- R10: At most one of x_load, y_load and wr_req is high in any cycle. Each is high for one cycle per accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_is_data | input | 1 | 1 = RAM data byte, 0 = command byte |
| byte_in | input | 8 | Received byte |
| pwr_down | output | 1 | Power-down flag |
| addr_vert | output | 1 | 1 = vertical auto-increment order |
| ext_page | output | 1 | 1 = extended instruction page |
| disp_mode | output | 2 | Display mode {D,E} |
| temp_coef | output | 2 | Temperature coefficient select |
| bias_code | output | 3 | Bias ratio code |
| vop_code | output | 7 | Operating-voltage code |
| pump_off | output | 1 | Voltage generator off (vop_code is zero) |
| x_load | output | 1 | One-cycle column address load |
| x_value | output | 7 | Column address for x_load |
| y_load | output | 1 | One-cycle bank address load |
| y_value | output | 3 | Bank address for y_load |
| wr_req | output | 1 | One-cycle RAM write request |
| wr_data | output | 8 | Byte for wr_req |

## Verification
The risky overlap is the cycle in which a function-set byte writes the page register while the classifier already reads that register for a byte strobed right behind it. The bench drives its vector table back to back, so every page switch is followed at once by a page-specific opcode. The expected result assumes that opcode is decoded on the new page. A second overlap sets the pulse registers against the configuration registers: a data byte that carries a function-set pattern must raise wr_req and leave the page bit alone.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  parameter int BYTE_W = 8;
  parameter int XADR_W = 7;
  parameter int YADR_W = 3;
  parameter int VOP_W  = 7;
  parameter int BIAS_W = 3;
  parameter int TC_W   = 2;
  parameter int MODE_W = 2;
  localparam int POS_W = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    CC_NOP,
    CC_FUNC,
    CC_DISP,
    CC_SETY,
    CC_SETX,
    CC_TEMP,
    CC_BIAS,
    CC_VOP,
    CC_RSVD
  } cmd_class_e;

  // Position of the highest set bit; BYTE_W when the byte is zero.
  function automatic logic [POS_W-1:0] lead_one(input logic [BYTE_W-1:0] b);
    logic [POS_W-1:0] pos;
    pos = POS_W'(BYTE_W);
    for (int i = 0; i < BYTE_W; i++)
      if (b[i]) pos = POS_W'(i);
    return pos;
  endfunction

  // Class of a command byte on the selected page.
  function automatic cmd_class_e classify_cmd(input logic [BYTE_W-1:0] b,
                                              input logic ext);
    cmd_class_e c;
    case (lead_one(b))
      POS_W'(8): c = CC_NOP;
      POS_W'(7): c = ext ? CC_VOP : CC_SETX;
      POS_W'(6): c = (!ext && b[5:3] == 3'b000) ? CC_SETY : CC_RSVD;
      POS_W'(5): c = (b[4:3] == 2'b00) ? CC_FUNC : CC_RSVD;
      POS_W'(4): c = (ext && !b[3]) ? CC_BIAS : CC_RSVD;
      POS_W'(3): c = (!ext && !b[1]) ? CC_DISP : CC_RSVD;
      POS_W'(2): c = ext ? CC_TEMP : CC_RSVD;
      default:   c = CC_RSVD;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lcd_cmd_classify.sv
module lcd_cmd_classify
  import lcd_cmd_pkg::*;
(
  input  logic              cmd_fire,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              page_ext,
  output cmd_class_e        cmd_class,
  output logic              cmd_effective
);

  always_comb begin
    cmd_class     = classify_cmd(cmd_byte, page_ext);
    cmd_effective = cmd_fire && (cmd_class != CC_RSVD) && (cmd_class != CC_NOP);
  end

endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_effective,
  input  cmd_class_e        cmd_class,
  input  logic [BYTE_W-2:0] field,
  output logic              pd_q,
  output logic              vert_q,
  output logic              ext_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [TC_W-1:0]   tc_q,
  output logic [BIAS_W-1:0] bias_q,
  output logic [VOP_W-1:0]  vop_q,
  output logic              pump_off
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= 1'b1;
      vert_q <= 1'b0;
      ext_q  <= 1'b0;
      mode_q <= '0;
      tc_q   <= '0;
      bias_q <= '0;
      vop_q  <= '0;
    end else if (cmd_effective) begin
      case (cmd_class)
        CC_FUNC: begin
          pd_q   <= field[2];
          vert_q <= field[1];
          ext_q  <= field[0];
        end
        CC_DISP: mode_q <= {field[2], field[0]};
        CC_TEMP: tc_q   <= field[TC_W-1:0];
        CC_BIAS: bias_q <= field[BIAS_W-1:0];
        CC_VOP:  vop_q  <= field[VOP_W-1:0];
        default: ;
      endcase
    end
  end

  assign pump_off = (vop_q == '0);

endmodule

// File: rtl/lcd_evt_pulse.sv
module lcd_evt_pulse
  import lcd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_effective,
  input  logic              data_fire,
  input  cmd_class_e        cmd_class,
  input  logic [BYTE_W-1:0] byte_d,
  output logic              x_load,
  output logic [XADR_W-1:0] x_value,
  output logic              y_load,
  output logic [YADR_W-1:0] y_value,
  output logic              wr_req,
  output logic [BYTE_W-1:0] wr_data
);

  logic take_x, take_y;
  assign take_x = cmd_effective && (cmd_class == CC_SETX);
  assign take_y = cmd_effective && (cmd_class == CC_SETY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_load  <= 1'b0;
      y_load  <= 1'b0;
      wr_req  <= 1'b0;
      x_value <= '0;
      y_value <= '0;
      wr_data <= '0;
    end else begin
      x_load <= take_x;
      y_load <= take_y;
      wr_req <= data_fire;
      if (take_x)    x_value <= byte_d[XADR_W-1:0];
      if (take_y)    y_value <= byte_d[YADR_W-1:0];
      if (data_fire) wr_data <= byte_d;
    end
  end

endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
  import lcd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic              byte_is_data,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              pwr_down,
  output logic              addr_vert,
  output logic              ext_page,
  output logic [MODE_W-1:0] disp_mode,
  output logic [TC_W-1:0]   temp_coef,
  output logic [BIAS_W-1:0] bias_code,
  output logic [VOP_W-1:0]  vop_code,
  output logic              pump_off,
  output logic              x_load,
  output logic [XADR_W-1:0] x_value,
  output logic              y_load,
  output logic [YADR_W-1:0] y_value,
  output logic              wr_req,
  output logic [BYTE_W-1:0] wr_data
);

  logic       cmd_fire, data_fire, cmd_effective;
  cmd_class_e cmd_class;

  assign cmd_fire  = byte_valid && !byte_is_data;
  assign data_fire = byte_valid && byte_is_data;

  lcd_cmd_classify u_classify (
    .cmd_fire      (cmd_fire),
    .cmd_byte      (byte_in),
    .page_ext      (ext_page),
    .cmd_class     (cmd_class),
    .cmd_effective (cmd_effective)
  );

  lcd_cfg_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_effective (cmd_effective),
    .cmd_class     (cmd_class),
    .field         (byte_in[BYTE_W-2:0]),
    .pd_q          (pwr_down),
    .vert_q        (addr_vert),
    .ext_q         (ext_page),
    .mode_q        (disp_mode),
    .tc_q          (temp_coef),
    .bias_q        (bias_code),
    .vop_q         (vop_code),
    .pump_off      (pump_off)
  );

  lcd_evt_pulse u_pulse (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_effective (cmd_effective),
    .data_fire     (data_fire),
    .cmd_class     (cmd_class),
    .byte_d        (byte_in),
    .x_load        (x_load),
    .x_value       (x_value),
    .y_load        (y_load),
    .y_value       (y_value),
    .wr_req        (wr_req),
    .wr_data       (wr_data)
  );

  logic [16:0] cfg_bus;
  assign cfg_bus = {pwr_down, addr_vert, ext_page, disp_mode, temp_coef, bias_code, vop_code};

  // R8: reserved and no-operation bytes leave state and pulses untouched.
  a_r8_reserved_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && (cmd_class == CC_RSVD || cmd_class == CC_NOP))
      |=> ($stable(cfg_bus) && !x_load && !y_load));

  // R2: data bytes never touch configuration.
  a_r2_data_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |=> ($stable(cfg_bus) && wr_req));

  // R2: every write request traces to a data strobe of the same byte.
  a_r2_write_source: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ($past(data_fire) && wr_data == $past(byte_in)));

  // R5, R7: column load only from a basic-page byte with bit 7 set.
  a_r5_xload_source: assert property (@(posedge clk) disable iff (!rst_n)
    x_load |-> $past(cmd_fire && byte_in[7] && !ext_page));

  // R3: the page bit changes only through a function-set command.
  a_r3_page_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_page) |-> $past(cmd_fire && byte_in[7:3] == 5'b00100));

  // R9: a nonzero voltage code turns the pump flag off.
  a_r9_pump_on: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_effective && cmd_class == CC_VOP && byte_in[6:0] != 7'd0) |=> !pump_off);

  // R10: at most one event pulse per cycle.
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({x_load, y_load, wr_req}));

endmodule

// File: tb/test_lcd_cmd_decoder.sv
module test_lcd_cmd_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic       byte_is_data = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       pwr_down, addr_vert, ext_page, pump_off;
  logic [1:0] disp_mode, temp_coef;
  logic [2:0] bias_code, y_value;
  logic [6:0] vop_code, x_value;
  logic       x_load, y_load, wr_req;
  logic [7:0] wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lcd_cmd_decoder i_lcd_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_is_data(byte_is_data),
    .byte_in(byte_in), .pwr_down(pwr_down), .addr_vert(addr_vert), .ext_page(ext_page),
    .disp_mode(disp_mode), .temp_coef(temp_coef), .bias_code(bias_code),
    .vop_code(vop_code), .pump_off(pump_off), .x_load(x_load), .x_value(x_value),
    .y_load(y_load), .y_value(y_value), .wr_req(wr_req), .wr_data(wr_data)
  );

  // vector: [28] data flag, [27:20] byte, [19:3] expected {pd,v,h,mode,tc,bias,vop},
  // [2:0] expected pulses {x_load,y_load,wr_req}
  localparam int NV = 25;
  localparam logic [28:0] VECS [NV] = '{
    {1'b0, 8'h00, 3'b100, 2'b00, 2'b00, 3'd0, 7'h00, 3'b000}, // R8 nop
    {1'b0, 8'h0C, 3'b100, 2'b10, 2'b00, 3'd0, 7'h00, 3'b000}, // R4 normal
    {1'b0, 8'h0D, 3'b100, 2'b11, 2'b00, 3'd0, 7'h00, 3'b000}, // R4 inverse
    {1'b0, 8'h0E, 3'b100, 2'b11, 2'b00, 3'd0, 7'h00, 3'b000}, // R8 bit1 set
    {1'b0, 8'h45, 3'b100, 2'b11, 2'b00, 3'd0, 7'h00, 3'b010}, // R5 set Y=5
    {1'b0, 8'hD3, 3'b100, 2'b11, 2'b00, 3'd0, 7'h00, 3'b100}, // R5 set X=83
    {1'b0, 8'h14, 3'b100, 2'b11, 2'b00, 3'd0, 7'h00, 3'b000}, // R7 bias on basic
    {1'b0, 8'h06, 3'b100, 2'b11, 2'b00, 3'd0, 7'h00, 3'b000}, // R7 temp on basic
    {1'b1, 8'hA5, 3'b100, 2'b11, 2'b00, 3'd0, 7'h00, 3'b001}, // R2 data
    {1'b0, 8'h21, 3'b001, 2'b11, 2'b00, 3'd0, 7'h00, 3'b000}, // R3 to extended
    {1'b0, 8'h90, 3'b001, 2'b11, 2'b00, 3'd0, 7'h10, 3'b000}, // R6 vop
    {1'b0, 8'h13, 3'b001, 2'b11, 2'b00, 3'd3, 7'h10, 3'b000}, // R6 bias
    {1'b0, 8'h06, 3'b001, 2'b11, 2'b10, 3'd3, 7'h10, 3'b000}, // R6 temp
    {1'b0, 8'h0C, 3'b001, 2'b11, 2'b10, 3'd3, 7'h10, 3'b000}, // R7 disp on ext
    {1'b0, 8'h45, 3'b001, 2'b11, 2'b10, 3'd3, 7'h10, 3'b000}, // R7 set Y on ext
    {1'b0, 8'h1B, 3'b001, 2'b11, 2'b10, 3'd3, 7'h10, 3'b000}, // R8 bias bit3
    {1'b0, 8'h01, 3'b001, 2'b11, 2'b10, 3'd3, 7'h10, 3'b000}, // R8 0x01
    {1'b1, 8'h3C, 3'b001, 2'b11, 2'b10, 3'd3, 7'h10, 3'b001}, // R2 data on ext
    {1'b0, 8'h2A, 3'b001, 2'b11, 2'b10, 3'd3, 7'h10, 3'b000}, // R3 bad func
    {1'b0, 8'h23, 3'b011, 2'b11, 2'b10, 3'd3, 7'h10, 3'b000}, // R3 vertical
    {1'b0, 8'h80, 3'b011, 2'b11, 2'b10, 3'd3, 7'h00, 3'b000}, // R9 vop zero
    {1'b0, 8'h20, 3'b000, 2'b11, 2'b10, 3'd3, 7'h00, 3'b000}, // R3 to basic
    {1'b0, 8'h80, 3'b000, 2'b11, 2'b10, 3'd3, 7'h00, 3'b100}, // R5 set X=0
    {1'b0, 8'h08, 3'b000, 2'b00, 2'b10, 3'd3, 7'h00, 3'b000}, // R4 blank
    {1'b1, 8'h21, 3'b000, 2'b00, 2'b10, 3'd3, 7'h00, 3'b001}  // R2 data with func pattern
  };

  function automatic string vec_req(input int i);
    case (i)
      1, 2, 23:             return "R4";
      4, 5, 22:             return "R5";
      6, 7, 13, 14:         return "R7";
      8, 17, 24:            return "R2";
      9, 18, 19, 21:        return "R3";
      10, 11, 12:           return "R6";
      20:                   return "R9";
      default:              return "R8";
    endcase
  endfunction

  function automatic logic [16:0] cfg_now();
    return {pwr_down, addr_vert, ext_page, disp_mode, temp_coef, bias_code, vop_code};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_vec(input int i);
    logic [28:0] v;
    logic [7:0]  b;
    v = VECS[i];
    b = v[27:20];
    check(vec_req(i), $sformatf("cfg after vector %0d", i), 32'(cfg_now()), 32'(v[19:3]));
    check("R10", $sformatf("pulses after vector %0d", i), 32'({x_load, y_load, wr_req}), 32'(v[2:0]));
    check("R9", $sformatf("pump flag after vector %0d", i), 32'(pump_off), 32'(v[9:3] == 7'd0));
    if (v[2]) check("R5", "x_value", 32'(x_value), 32'(b[6:0]));
    if (v[1]) check("R5", "y_value", 32'(y_value), 32'(b[2:0]));
    if (v[0]) check("R2", "wr_data", 32'(wr_data), 32'(b));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: strobe during reset has no effect
    byte_valid = 1'b1; byte_is_data = 1'b0; byte_in = 8'h27;
    @(negedge clk);
    byte_valid = 1'b0;
    check("R1", "cfg in reset", 32'(cfg_now()), 32'h10000);
    check("R1", "pulses in reset", 32'({x_load, y_load, wr_req}), 32'd0);
    check("R1", "addresses in reset", 32'({x_value, y_value}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cfg after release", 32'(cfg_now()), 32'h10000);
    check("R9", "pump flag after reset", 32'(pump_off), 32'd1);

    // back-to-back table walk
    for (int i = 0; i < NV; i++) begin
      byte_valid   = 1'b1;
      byte_is_data = VECS[i][28];
      byte_in      = VECS[i][27:20];
      @(negedge clk);
      check_vec(i);
    end
    byte_valid = 1'b0;
    @(negedge clk);
    check("R10", "pulse length after table", 32'({x_load, y_load, wr_req}), 32'd0);

    // R2: idle byte with valid low does nothing
    byte_in = 8'h21;
    @(negedge clk);
    check("R2", "no strobe, no change", 32'(cfg_now()), 32'({3'b000, 2'b00, 2'b10, 3'd3, 7'h00}));

    // R10: isolated set-Y pulse is one cycle long
    byte_valid = 1'b1; byte_is_data = 1'b0; byte_in = 8'h42;
    @(negedge clk);
    byte_valid = 1'b0;
    check("R5", "y_load isolated", 32'({y_load, y_value}), 32'({1'b1, 3'd2}));
    @(negedge clk);
    check("R10", "y_load drops", 32'(y_load), 32'd0);
    check("R10", "y_value held", 32'(y_value), 32'd2);

    // R1: reset in mid-run restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "cfg after second reset", 32'(cfg_now()), 32'h10000);
    check("R1", "addresses after second reset", 32'({x_value, y_value}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule